// File: doc/BRIEF.md
# Multiplexed Asynchronous Memory Port

This block moves 32-bit words between an on-chip requester and an external asynchronous memory. Addresses and data travel over the same 16 lines. Each narrow transfer starts with an address phase marked by an address-latch pulse. A read or write strobe follows, and its length in core clocks is programmable.

The port has two modes, chosen by a configuration input:

- **Byte mode:** 8-bit data with a 24-bit external address. Four transfers make one word.
- **Halfword mode:** 16-bit data with a 16-bit external address. Two transfers make one word.

Words are assembled and split little-endian: the first transfer carries the least significant part.

Requests arrive on a valid/ready interface that a DMA engine can drive. A single-cycle response pulse marks the end of each word.

Top module: `mux_mem_port`

## Requirements
- R1: After reset, `req_ready` is 1 and `ext_ale`, `ext_rd`, `ext_wr`, `ext_ad_oe` and `rsp_valid` are all 0.
- R2: Each narrow transfer runs in this order. First, one cycle with `ext_ale`=1 and `ext_ad_oe`=2'b11. Next, one cycle with `ext_ale`=0 and the same line value still driven. Then the strobe cycles. Last, one idle cycle with `ext_ale`, `ext_rd`, `ext_wr` and `ext_ad_oe` all 0.
- R3: In byte mode (`cfg_mode16`=0), a word takes four transfers, and transfer k uses address `req_addr`+k modulo 2^24. Its address phase drives address bits [23:8] on the lines. Its strobe drives address bits [7:0] on lines [15:8].
- R4: In halfword mode (`cfg_mode16`=1), a word takes two transfers, and transfer k uses address (`req_addr`[15:0]+k) modulo 2^16. Its address phase drives those 16 bits.
- R5: Packing is little-endian. In byte mode, transfer k carries word bits [8k+7:8k] on lines [7:0]. In halfword mode, it carries bits [16k+15:16k] on lines [15:0]. This holds for write output and for read assembly alike.
- R6: The strobe lasts `cfg_strobe_cycles` cycles for values 2 to 31. Values 0 and 1 give 2 cycles. The value is taken when the request is accepted.
- R7: During a read strobe, `ext_ad_oe`[0] (lines [7:0]) is 0. `ext_ad_oe`[1] (lines [15:8]) is 1 in byte mode and 0 in halfword mode. Read data is taken from `ext_ad_in` on the last strobe cycle.
- R8: `rsp_valid` is high for exactly one cycle: the idle cycle of the final transfer. For reads, `rsp_rdata` holds the assembled word in that cycle.
- R9: `req_ready` is 0 from acceptance through the `rsp_valid` cycle. It is 1 again in the following cycle.
- R10: `ext_rd` and `ext_wr` are never high together, and `ext_ale` is never high together with either strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode16 | input | 1 | 0: byte data with 24-bit address; 1: halfword data with 16-bit address |
| cfg_strobe_cycles | input | 5 | Strobe length in core clocks (clamped to at least 2) |
| req_valid | input | 1 | Word request present |
| req_ready | output | 1 | Port can accept a request |
| req_write | input | 1 | 1 = write word, 0 = read word |
| req_addr | input | 24 | External address of the first narrow transfer |
| req_wdata | input | 32 | Word to write |
| rsp_valid | output | 1 | Word finished (single-cycle pulse) |
| rsp_rdata | output | 32 | Assembled read word |
| ext_ale | output | 1 | Address-latch enable, active high |
| ext_rd | output | 1 | Read strobe, active high |
| ext_wr | output | 1 | Write strobe, active high |
| ext_ad_out | output | 16 | Value driven on the shared lines |
| ext_ad_oe | output | 2 | Drive enables: bit 1 for lines [15:8], bit 0 for lines [7:0] |
| ext_ad_in | input | 16 | Value sampled from the shared lines |

## Verification
The bench builds the port with its default parameters: 16 shared lines, 32-bit words, a 24-bit address and a 5-bit strobe counter. The counter width reaches the whole strobe range, from the clamped values 0 and 1 up to 31.

The 24-bit address lets a byte-mode word carry across the boundary where the address-phase field changes. Halfword mode can wrap from 0xFFFF to 0x0000 inside one word.

A bench-side memory model answers reads with values computed from the latched address. Any lane, order or address mistake therefore appears in the assembled word.

// File: rtl/mmp_pkg.sv
package mmp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_HOLD, ST_STROBE, ST_TURN
  } mmp_state_t;

  function automatic logic [4:0] clamp_strobe(input logic [4:0] raw);
    return (raw < 5'd2) ? 5'd2 : raw;
  endfunction
endpackage

// File: rtl/mmp_strobe_timer.sv
module mmp_strobe_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  input  logic [CNT_W-1:0] span,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (start) cnt_q <= CNT_W'(1);
    else if (run)   cnt_q <= cnt_q + CNT_W'(1);
  end

  assign last = run && (cnt_q == span);
endmodule

// File: rtl/mmp_lane_map.sv
module mmp_lane_map #(
  parameter int WORD_W = 32,
  parameter int AD_W   = 16
) (
  input  logic              mode16,
  input  logic [1:0]        beat,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [WORD_W-1:0] rd_acc,
  input  logic [AD_W-1:0]   pad_in,
  output logic [AD_W-1:0]   lane_out,
  output logic [WORD_W-1:0] acc_next
);
  localparam int NARROW_W = AD_W / 2;

  int lo_idx;
  always_comb begin
    lo_idx   = mode16 ? int'(beat[0]) * AD_W : int'(beat) * NARROW_W;
    lane_out = '0;
    acc_next = rd_acc;
    if (mode16) begin
      lane_out                = wr_word[lo_idx +: AD_W];
      acc_next[lo_idx +: AD_W] = pad_in;
    end else begin
      lane_out[NARROW_W-1:0]       = wr_word[lo_idx +: NARROW_W];
      acc_next[lo_idx +: NARROW_W] = pad_in[NARROW_W-1:0];
    end
  end
endmodule

// File: rtl/mux_mem_port.sv
module mux_mem_port
  import mmp_pkg::*;
#(
  parameter int AD_W   = 16,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_mode16,
  input  logic [CNT_W-1:0]  cfg_strobe_cycles,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              ext_ale,
  output logic              ext_rd,
  output logic              ext_wr,
  output logic [AD_W-1:0]   ext_ad_out,
  output logic [1:0]        ext_ad_oe,
  input  logic [AD_W-1:0]   ext_ad_in
);
  localparam int NARROW_W = AD_W / 2;

  mmp_state_t        st_q;
  logic              wr_op_q, mode16_q, rsp_q, ale_q, rd_q, wr_q;
  logic [CNT_W-1:0]  span_q;
  logic [ADDR_W-1:0] addr_q, addr_nx;
  logic [WORD_W-1:0] wdata_q, rdata_q, acc_nx;
  logic [1:0]        beat_q, oe_q;
  logic [AD_W-1:0]   ad_q, lane;
  logic              strobe_last, final_beat;

  function automatic logic [AD_W-1:0] addr_field(input logic [ADDR_W-1:0] a, input logic m16);
    return m16 ? a[AD_W-1:0] : a[ADDR_W-1:ADDR_W-AD_W];
  endfunction

  assign final_beat = mode16_q ? (beat_q == 2'd1) : (beat_q == 2'd3);
  assign addr_nx    = mode16_q ? {addr_q[ADDR_W-1:AD_W], addr_q[AD_W-1:0] + AD_W'(1)}
                               : addr_q + ADDR_W'(1);

  mmp_strobe_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst),
    .start(st_q == ST_HOLD), .run(st_q == ST_STROBE),
    .span(span_q), .last(strobe_last)
  );

  mmp_lane_map #(.WORD_W(WORD_W), .AD_W(AD_W)) u_lanes (
    .mode16(mode16_q), .beat(beat_q), .wr_word(wdata_q), .rd_acc(rdata_q),
    .pad_in(ext_ad_in), .lane_out(lane), .acc_next(acc_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE; wr_op_q <= 1'b0; mode16_q <= 1'b0; span_q <= CNT_W'(2);
      addr_q <= '0; wdata_q <= '0; rdata_q <= '0; beat_q <= '0;
      ale_q <= 1'b0; rd_q <= 1'b0; wr_q <= 1'b0; oe_q <= '0; ad_q <= '0; rsp_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_valid) begin
          st_q     <= ST_ADDR;
          wr_op_q  <= req_write;
          mode16_q <= cfg_mode16;
          span_q   <= clamp_strobe(cfg_strobe_cycles);
          addr_q   <= req_addr;
          wdata_q  <= req_wdata;
          beat_q   <= '0;
          ale_q    <= 1'b1;
          oe_q     <= 2'b11;
          ad_q     <= addr_field(req_addr, cfg_mode16);
        end
        ST_ADDR: begin
          st_q  <= ST_HOLD;
          ale_q <= 1'b0;
        end
        ST_HOLD: begin
          st_q <= ST_STROBE;
          rd_q <= !wr_op_q;
          wr_q <= wr_op_q;
          oe_q <= wr_op_q ? 2'b11 : (mode16_q ? 2'b00 : 2'b10);
          ad_q <= mode16_q ? lane : {addr_q[NARROW_W-1:0], lane[NARROW_W-1:0]};
        end
        ST_STROBE: if (strobe_last) begin
          st_q <= ST_TURN;
          rd_q <= 1'b0;
          wr_q <= 1'b0;
          oe_q <= 2'b00;
          if (!wr_op_q) rdata_q <= acc_nx;
          if (final_beat) rsp_q <= 1'b1;
        end
        ST_TURN: begin
          rsp_q <= 1'b0;
          if (final_beat) st_q <= ST_IDLE;
          else begin
            st_q   <= ST_ADDR;
            beat_q <= beat_q + 2'd1;
            addr_q <= addr_nx;
            ale_q  <= 1'b1;
            oe_q   <= 2'b11;
            ad_q   <= addr_field(addr_nx, mode16_q);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (st_q == ST_IDLE);
  assign rsp_valid  = rsp_q;
  assign rsp_rdata  = rdata_q;
  assign ext_ale    = ale_q;
  assign ext_rd     = rd_q;
  assign ext_wr     = wr_q;
  assign ext_ad_oe  = oe_q;
  assign ext_ad_out = ad_q;

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst) !(ext_rd && ext_wr));
  p_ale_alone_r10: assert property (@(posedge clk) disable iff (rst) ext_ale |-> !(ext_rd || ext_wr));
  p_latch_hold_r2: assert property (@(posedge clk) disable iff (rst)
    ext_ale |=> (!ext_ale && ext_ad_oe == 2'b11 && $stable(ext_ad_out)));
  p_turnaround_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(ext_rd || ext_wr) |-> (ext_ad_oe == 2'b00 && !ext_ale));
  p_read_release_r7: assert property (@(posedge clk) disable iff (rst) ext_rd |-> !ext_ad_oe[0]);
  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (rst) rsp_valid |=> !rsp_valid);
  p_busy_r9: assert property (@(posedge clk) disable iff (rst) rsp_valid |-> !req_ready);
endmodule

// File: tb/mux_mem_port_tb.sv
module mux_mem_port_tb;
  logic        clk = 1'b0, rst = 1'b1;
  logic        cfg_mode16 = 1'b0;
  logic [4:0]  cfg_strobe_cycles = 5'd2;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, ext_ale, ext_rd, ext_wr;
  logic [31:0] rsp_rdata;
  logic [15:0] ext_ad_out, ext_ad_in;
  logic [1:0]  ext_ad_oe;
  logic [15:0] ale_hi = '0;
  logic        m16_tb = 1'b0;
  int checks = 0, fails = 0, cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mux_mem_port u_dut (
    .clk(clk), .rst(rst), .cfg_mode16(cfg_mode16), .cfg_strobe_cycles(cfg_strobe_cycles),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ext_ale(ext_ale),
    .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_ad_out(ext_ad_out), .ext_ad_oe(ext_ad_oe),
    .ext_ad_in(ext_ad_in)
  );

  function automatic logic [7:0] mem8(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction
  function automatic logic [15:0] mem16(input logic [15:0] a);
    return {a[7:0] ^ 8'hC3, a[15:8] ^ 8'h3C};
  endfunction

  always_comb ext_ad_in = m16_tb ? mem16(ale_hi) : {8'h00, mem8({ale_hi, ext_ad_out[15:8]})};

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_txn(input bit wr, input bit m16, input logic [23:0] a,
                         input logic [31:0] d, input logic [4:0] len);
    int beat = -1, run = 0, nbeats, elen;
    bit prev_ale = 0, got = 0;
    logic [15:0] prev_ad = '0;
    logic [23:0] ak;
    logic [31:0] exp_word = '0;
    nbeats = m16 ? 2 : 4;
    elen   = (len < 5'd2) ? 2 : int'(len);
    for (int k = 0; k < nbeats; k++)
      if (m16) exp_word[16*k +: 16] = mem16(a[15:0] + 16'(k));
      else     exp_word[8*k +: 8]   = mem8(a + 24'(k));
    @(negedge clk);
    m16_tb = m16; cfg_mode16 = m16; cfg_strobe_cycles = len;
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    for (int cyc = 0; cyc < 400 && !got; cyc++) begin
      @(negedge clk);
      if (cyc == 0) begin
        req_valid = 1'b0;
        cfg_strobe_cycles = 5'($urandom);  // R6: change after acceptance has no effect
        cfg_mode16 = ~m16;
      end
      check(req_ready == 1'b0, "R9 busy", 32'(req_ready), 0);
      if (prev_ale) check(!ext_ale && ext_ad_oe == 2'b11 && ext_ad_out == prev_ad, "R2 hold",
                          {ext_ale, ext_ad_oe, ext_ad_out}, {1'b0, 2'b11, prev_ad});
      if (ext_ale) begin
        beat++;
        ale_hi = ext_ad_out;
        ak = m16 ? {8'h00, a[15:0] + 16'(beat)} : a + 24'(beat);
        check(ext_ad_oe == 2'b11, "R2 addr oe", 32'(ext_ad_oe), 3);
        if (m16) check(ext_ad_out == ak[15:0], "R4 addr", 32'(ext_ad_out), 32'(ak[15:0]));
        else     check(ext_ad_out == ak[23:8], "R3 addr", 32'(ext_ad_out), 32'(ak[23:8]));
      end
      check(!(ext_rd && ext_wr) && !(ext_ale && (ext_rd || ext_wr)), "R10",
            {ext_ale, ext_rd, ext_wr}, 0);
      if (ext_rd || ext_wr) begin
        run++;
        check(ext_wr == wr, "R2 strobe kind", 32'(ext_wr), 32'(wr));
        if (wr) begin
          check(ext_ad_oe == 2'b11, "R5 write oe", 32'(ext_ad_oe), 3);
          if (m16) check(ext_ad_out == d[16*beat +: 16], "R5 write half", 32'(ext_ad_out), 32'(d[16*beat +: 16]));
          else     check(ext_ad_out == {ak[7:0], d[8*beat +: 8]}, "R5 write byte",
                         32'(ext_ad_out), 32'({ak[7:0], d[8*beat +: 8]}));
        end else begin
          check(ext_ad_oe == (m16 ? 2'b00 : 2'b10), "R7 read oe", 32'(ext_ad_oe), m16 ? 0 : 2);
          if (!m16) check(ext_ad_out[15:8] == ak[7:0], "R3 low addr", 32'(ext_ad_out[15:8]), 32'(ak[7:0]));
        end
      end else if (run > 0) begin
        check(run == elen, "R6 strobe length", run, elen);
        check(ext_ad_oe == 2'b00 && !ext_ale, "R2 turnaround", {ext_ale, ext_ad_oe}, 0);
        run = 0;
      end
      if (rsp_valid) begin
        got = 1;
        check(beat + 1 == nbeats, m16 ? "R4 count" : "R3 count", beat + 1, nbeats);
        if (!wr) check(rsp_rdata == exp_word, "R8 read word", rsp_rdata, exp_word);
      end
      prev_ale = ext_ale; prev_ad = ext_ad_out;
    end
    check(got, "R8 response", 32'(got), 1);
    @(negedge clk);
    check(req_ready && !rsp_valid, "R9 ready again", {rsp_valid, req_ready}, 1);
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected<200000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready && !ext_ale && !ext_rd && !ext_wr && ext_ad_oe == 2'b00 && !rsp_valid,
          "R1 reset", {req_ready, ext_ale, ext_rd, ext_wr, ext_ad_oe, rsp_valid}, 32'h40);
    run_txn(1, 0, 24'h0000FE, 32'hA1B2C3D4, 5'd0);   // R6 clamp, R3 carry into high field
    run_txn(0, 0, 24'h0000FE, 32'h0, 5'd1);          // R6 clamp, R7 read
    run_txn(0, 1, 24'h12FFFF, 32'h0, 5'd31);         // R4 wrap, R6 max
    run_txn(1, 1, 24'h00FFFF, 32'h13572468, 5'd2);   // R5 halfword order
    run_txn(0, 0, 24'hFFFFFE, 32'h0, 5'd3);          // R3 24-bit wrap
    for (int i = 0; i < 24; i++)
      run_txn(1'($urandom), 1'($urandom), 24'($urandom), $urandom, 5'($urandom));
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule